// File: doc/BRIEF.md
# Word Serializer with Row and Column Parity

This block sits between a 36-bit parallel word port and a serial disk bit stream. In the write direction it takes a word, appends an odd parity bit, and sends the 37 bits out serially, most significant data bit first and the parity bit last. Each word it accepts is also folded by XOR into a 36-bit longitudinal accumulator. At the end of a sector the controller asks for the parity word, and the block sends the bitwise complement of the accumulator, with its own odd parity bit. Every sector thus carries a parity bit on each word and one parity column across all of its words.

In the read direction the block gathers 37 serial bits into a word and its parity bit. It presents the word for one cycle and checks that the 37 bits hold an odd number of ones. Data words are folded into the same accumulator. When the controller marks the incoming word as the sector parity word, the block compares that word with the complement of the accumulator instead of folding it in. A word parity error and a sector parity error are each held until the next sector clear. The accumulator can also absorb a header word. The upper half takes cylinder, head and sector fields at fixed positions, and each half of the accumulator can be cleared on its own.

Top module: `word_serdes_lpar`

## Requirements
- R1: One cycle after `wr_load` is accepted, `ser_valid` stays high for exactly 37 cycles. During those cycles `ser_out` carries `wr_word[35]` down to `wr_word[0]`, followed by the parity bit.
- R2: The parity bit sent after a word makes the number of ones in the 37 transmitted bits odd.
- R3: `wr_load` and `wr_lpw` are accepted only when no word is being sent and no read word is partly received. If either is raised at any other time, the stream in progress and `acc` are unchanged.
- R4: An accepted `wr_load` XORs `wr_word` into `acc`, visible on the next cycle.
- R5: An accepted `wr_lpw` (with `wr_load` low) sends `~acc` with its parity bit in the R1 format and leaves `acc` unchanged.
- R6: When no word is being sent, each cycle with `ser_in_valid` high shifts in `ser_in`, first bit as bit 35. On the 37th bit, `rd_valid` is high for one cycle on the next clock, and `rd_word` holds the first 36 bits.
- R7: If a received 37-bit group holds an even number of ones, `word_perr` is set. It stays set until `sector_clr`.
- R8: A received word whose 37th bit arrives with `rd_lpw` low is XORed into `acc`.
- R9: A received word whose 37th bit arrives with `rd_lpw` high is not folded into `acc`. If it differs from `~acc`, `lpar_err` is set, and it stays set until `sector_clr`.
- R10: A `hdr_xor` cycle XORs `hdr_cyl` into `acc[25:18]`, `hdr_head` into `acc[30:26]` and `hdr_sect` into `acc[35:32]`. It leaves `acc[31]` and `acc[17:0]` unchanged.
- R11: `half_clr[0]` clears `acc[17:0]` and `half_clr[1]` clears `acc[35:18]`. Each leaves the other half unchanged.
- R12: `sector_clr` clears `acc`, `word_perr`, `lpar_err` and the received-bit count, and takes priority over every other update.
- R13: After reset, `ser_valid`, `rd_valid`, `word_perr` and `lpar_err` are low and `acc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sector_clr | input | 1 | Clears the accumulator, the error flags and the read bit count |
| half_clr | input | 2 | Bit 0 clears the lower accumulator half, bit 1 the upper half |
| wr_load | input | 1 | Start sending `wr_word` |
| wr_word | input | 36 | Word to send |
| wr_lpw | input | 1 | Start sending the complemented accumulator |
| ser_out | output | 1 | Serial write bit |
| ser_valid | output | 1 | `ser_out` carries a bit |
| ser_in | input | 1 | Serial read bit |
| ser_in_valid | input | 1 | `ser_in` carries a bit |
| rd_lpw | input | 1 | The current read word is the sector parity word |
| rd_word | output | 36 | Last received word |
| rd_valid | output | 1 | One-cycle pulse on a completed read word |
| word_perr | output | 1 | Sticky per-word odd parity error |
| lpar_err | output | 1 | Sticky sector longitudinal parity error |
| hdr_xor | input | 1 | Fold the header fields into the upper accumulator half |
| hdr_cyl | input | 8 | Cylinder address |
| hdr_head | input | 5 | Head address |
| hdr_sect | input | 4 | Sector address |
| acc | output | 36 | Longitudinal accumulator |

## Verification
The assertions assume that only one source updates the accumulator in a cycle. A header fold, a half clear, an accepted write and a completed read word are never raised together, and `rd_lpw` is meaningful only on the 37th bit of a read word. The stimulus keeps to this: it runs write words, read words, header folds and clears one after another and never overlaps them. The only exception is the deliberate stray `wr_load` raised in the middle of a transmission. Random words come from `$urandom` with a fixed seed, and directed words cover all-zero, all-ones, bad parity, a wrong sector parity word and a clear in the middle of a word.

// File: rtl/word_serdes_lpar.sv
module word_serdes_lpar #(
  parameter int W      = 36,
  parameter int CYL_W  = 8,
  parameter int HEAD_W = 5,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sector_clr,
  input  logic [1:0]        half_clr,
  input  logic              wr_load,
  input  logic [W-1:0]      wr_word,
  input  logic              wr_lpw,
  output logic              ser_out,
  output logic              ser_valid,
  input  logic              ser_in,
  input  logic              ser_in_valid,
  input  logic              rd_lpw,
  output logic [W-1:0]      rd_word,
  output logic              rd_valid,
  output logic              word_perr,
  output logic              lpar_err,
  input  logic              hdr_xor,
  input  logic [CYL_W-1:0]  hdr_cyl,
  input  logic [HEAD_W-1:0] hdr_head,
  input  logic [SECT_W-1:0] hdr_sect,
  output logic [W-1:0]      acc
);

  localparam int H       = W / 2;
  localparam int CNT_W   = $clog2(W + 1);
  localparam int HEAD_LO = H + CYL_W;
  localparam int GAP_BIT = HEAD_LO + HEAD_W;
  localparam int SECT_LO = W - SECT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W);

  logic [W:0]       sr;
  logic [CNT_W-1:0] wcnt, rcnt;
  logic             busy;

  wire wr_go   = !busy && rcnt == '0 && (wr_load || wr_lpw);
  wire rd_take = ser_in_valid && !busy && !wr_go;
  wire rd_done = rd_take && rcnt == LAST;

  logic [W-1:0] wr_src, rd_data, hdr_word, acc_xor, acc_n;

  assign wr_src    = wr_load ? wr_word : ~acc;
  assign rd_data   = sr[W-1:0];
  assign ser_out   = sr[W];
  assign ser_valid = busy;

  always_comb begin
    hdr_word = '0;
    hdr_word[H +: CYL_W]        = hdr_cyl;
    hdr_word[HEAD_LO +: HEAD_W] = hdr_head;
    hdr_word[SECT_LO +: SECT_W] = hdr_sect;
  end

  assign acc_xor = ((wr_go && wr_load)    ? wr_word  : '0)
                 ^ ((rd_done && !rd_lpw)  ? rd_data  : '0)
                 ^ (hdr_xor               ? hdr_word : '0);

  always_comb begin
    acc_n = acc ^ acc_xor;
    if (half_clr[0]) acc_n[H-1:0] = '0;
    if (half_clr[1]) acc_n[W-1:H] = '0;
    if (sector_clr)  acc_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      wcnt <= '0;
      rcnt <= '0;
      busy <= 1'b0;
    end else begin
      if (wr_go) begin
        sr   <= {wr_src, ~^wr_src};
        busy <= 1'b1;
        wcnt <= '0;
      end else if (busy) begin
        sr   <= {sr[W-1:0], 1'b0};
        wcnt <= wcnt + 1'b1;
        if (wcnt == LAST) busy <= 1'b0;
      end else if (rd_take) begin
        sr   <= {sr[W-1:0], ser_in};
        rcnt <= rd_done ? '0 : rcnt + 1'b1;
      end
      if (sector_clr) rcnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word   <= '0;
      rd_valid  <= 1'b0;
      word_perr <= 1'b0;
      lpar_err  <= 1'b0;
      acc       <= '0;
    end else begin
      rd_valid <= rd_done;
      if (rd_done) rd_word <= rd_data;
      if (sector_clr) word_perr <= 1'b0;
      else if (rd_done && !(^{rd_data, ser_in})) word_perr <= 1'b1;
      if (sector_clr) lpar_err <= 1'b0;
      else if (rd_done && rd_lpw && acc != ~rd_data) lpar_err <= 1'b1;
      acc <= acc_n;
    end
  end

  wire quiet_acc = !hdr_xor && half_clr == 2'b00 && !sector_clr;

  assert_start_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> $past(wr_load || wr_lpw));

  assert_odd_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (^sr) == 1'b1);

  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && (wr_load || wr_lpw) && quiet_acc) |=> acc == $past(acc));

  assert_lpw_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !wr_load && quiet_acc) |=> acc == $past(acc));

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_perr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_perr && !sector_clr) |=> word_perr);

  assert_lerr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lpar_err && !sector_clr) |=> lpar_err);

  assert_hdr_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_xor && !sector_clr && half_clr == 2'b00 && !wr_go && !rd_done)
      |=> acc[GAP_BIT] == $past(acc[GAP_BIT]) && acc[H-1:0] == $past(acc[H-1:0]));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sector_clr |=> (acc == '0 && !word_perr && !lpar_err));

endmodule

// File: tb/test_word_serdes_lpar.sv
module test_word_serdes_lpar;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sector_clr = 0, wr_load = 0, wr_lpw = 0, ser_in = 0, ser_in_valid = 0, rd_lpw = 0, hdr_xor = 0;
  logic [1:0] half_clr = 0;
  logic [35:0] wr_word = 0;
  logic [7:0] hdr_cyl = 0;
  logic [4:0] hdr_head = 0;
  logic [3:0] hdr_sect = 0;
  logic ser_out, ser_valid, rd_valid, word_perr, lpar_err;
  logic [35:0] rd_word, acc;

  int checks = 0, fails = 0;
  logic [35:0] acc_m = 0;
  bit perr_m = 0, lerr_m = 0;

  always #4 clk = ~clk;

  word_serdes_lpar i_word_serdes_lpar (
    .clk(clk), .rst_n(rst_n), .sector_clr(sector_clr), .half_clr(half_clr),
    .wr_load(wr_load), .wr_word(wr_word), .wr_lpw(wr_lpw),
    .ser_out(ser_out), .ser_valid(ser_valid),
    .ser_in(ser_in), .ser_in_valid(ser_in_valid), .rd_lpw(rd_lpw),
    .rd_word(rd_word), .rd_valid(rd_valid), .word_perr(word_perr), .lpar_err(lpar_err),
    .hdr_xor(hdr_xor), .hdr_cyl(hdr_cyl), .hdr_head(hdr_head), .hdr_sect(hdr_sect),
    .acc(acc));

  function automatic bit odd_bit(input logic [35:0] w);
    return ~^w;
  endfunction

  function automatic logic [35:0] hdr_model(input logic [7:0] c, input logic [4:0] h, input logic [3:0] s);
    logic [35:0] r = '0;
    for (int i = 0; i < 8; i++) r[18 + i] = c[i];
    for (int i = 0; i < 5; i++) r[26 + i] = h[i];
    for (int i = 0; i < 4; i++) r[32 + i] = s[i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(acc == acc_m, req, "acc", 64'(acc), 64'(acc_m));
    check(word_perr == perr_m, req, "word_perr", 64'(word_perr), 64'(perr_m));
    check(lpar_err == lerr_m, req, "lpar_err", 64'(lpar_err), 64'(lerr_m));
  endtask

  task automatic send(input logic [35:0] w, input bit lpw, input bit inject, input string req);
    logic [36:0] got = 0;
    logic [35:0] exp_w;
    int vcnt = 0;
    exp_w = lpw ? ~acc_m : w;
    wr_word = w; wr_load = !lpw; wr_lpw = lpw;
    @(negedge clk);
    wr_load = 0; wr_lpw = 0;
    if (!lpw) acc_m = acc_m ^ w;
    for (int i = 0; i < 37; i++) begin
      got = {got[35:0], ser_out};
      vcnt += int'(ser_valid);
      if (inject && i == 10) begin wr_word = ~w; wr_load = 1; end
      else begin wr_load = 0; end
      @(negedge clk);
    end
    wr_load = 0;
    check(got == {exp_w, odd_bit(exp_w)}, req, "serial frame (R1 R2)", 64'(got), 64'({exp_w, odd_bit(exp_w)}));
    check(vcnt == 37 && !ser_valid, req, "valid length R1", 64'(vcnt), 64'd37);
    check(acc == acc_m, req, "acc after write R4", 64'(acc), 64'(acc_m));
  endtask

  task automatic recv(input logic [35:0] d, input bit par_ok, input bit lpw, input string req);
    for (int i = 0; i < 37; i++) begin
      ser_in = (i < 36) ? d[35 - i] : (par_ok ? odd_bit(d) : ~odd_bit(d));
      ser_in_valid = 1;
      rd_lpw = lpw && i == 36;
      @(negedge clk);
    end
    ser_in_valid = 0; rd_lpw = 0;
    if (!par_ok) perr_m = 1;
    if (lpw) begin
      if (acc_m != ~d) lerr_m = 1;
    end else acc_m = acc_m ^ d;
    check(rd_valid == 1'b1, req, "rd_valid R6", 64'(rd_valid), 64'd1);
    check(rd_word == d, req, "rd_word R6", 64'(rd_word), 64'(d));
    check_state(req);
    @(negedge clk);
  endtask

  task automatic clr_sector();
    sector_clr = 1; @(negedge clk); sector_clr = 0;
    acc_m = 0; perr_m = 0; lerr_m = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [35:0] w;
    logic [35:0] words [4];
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!ser_valid && !rd_valid, "R13", "reset valids", 64'({ser_valid, rd_valid}), 64'd0);
    check_state("R13");

    send(36'h0, 0, 0, "R1");
    send('1, 0, 0, "R2");
    for (int k = 0; k < 4; k++) begin
      w = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      send(w, 0, 0, "R4");
    end
    w = 36'hA_5A5A_5A5A;
    send(w, 0, 1, "R3");
    send(36'h0, 1, 0, "R5");
    check_state("R5");

    clr_sector();
    check_state("R12");

    for (int k = 0; k < 4; k++) begin
      words[k] = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      recv(words[k], 1, 0, "R8");
    end
    recv(~acc_m, 1, 1, "R9");
    recv(36'h1_2345_6789, 0, 0, "R7");
    recv(36'h0_0F0F_0F0F, 1, 0, "R7");
    clr_sector();
    check_state("R12");
    recv(36'h7_7777_0000, 1, 0, "R8");
    recv(36'h7_7777_0000, 1, 1, "R9");

    clr_sector();
    send('1, 0, 0, "R10");
    hdr_cyl = 8'hC3; hdr_head = 5'h15; hdr_sect = 4'h9; hdr_xor = 1;
    @(negedge clk);
    hdr_xor = 0;
    acc_m = acc_m ^ hdr_model(8'hC3, 5'h15, 4'h9);
    check(acc == acc_m, "R10", "header fold", 64'(acc), 64'(acc_m));
    for (int k = 0; k < 3; k++) begin
      hdr_cyl = 8'($urandom); hdr_head = 5'($urandom); hdr_sect = 4'($urandom); hdr_xor = 1;
      @(negedge clk);
      hdr_xor = 0;
      acc_m = acc_m ^ hdr_model(hdr_cyl, hdr_head, hdr_sect);
      check(acc == acc_m, "R10", "random header fold", 64'(acc), 64'(acc_m));
    end

    half_clr = 2'b01; @(negedge clk); half_clr = 0;
    acc_m[17:0] = 0;
    check(acc == acc_m, "R11", "low half clear", 64'(acc), 64'(acc_m));
    send(36'hF_FFFF_FFFF, 0, 0, "R11");
    half_clr = 2'b10; @(negedge clk); half_clr = 0;
    acc_m[35:18] = 0;
    check(acc == acc_m, "R11", "high half clear", 64'(acc), 64'(acc_m));

    for (int i = 0; i < 10; i++) begin
      ser_in = 1; ser_in_valid = 1; @(negedge clk);
    end
    ser_in_valid = 0;
    clr_sector();
    recv(36'h3_C3C3_C3C3, 1, 0, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule